// File: doc/BRIEF.md
# Receive FIFO Service Request Controller

This block watches the occupancy of a serial receiver's buffer and decides when the host must be asked to collect characters. It does not store any data. It reads the buffer's fill count and the strobes that mark each character written in by the receiver and each character read out by the host. From these it produces three signals: a data-available interrupt, a character-timeout interrupt and a ready line for a DMA engine.

In buffered mode, the data-available interrupt follows a selectable fill threshold. A timer measured in bit periods catches characters that remain in the buffer below the threshold for too long. The DMA ready line rises at the threshold or on a timeout, and it stays high until the buffer has been drained completely.

In unbuffered mode, the receiver uses a single holding register. The block keeps a full flag that is set when a character is written and cleared when the host reads it. Both the interrupt and the DMA ready line follow this flag.

Top module: `rx_svc_ctrl`

## Requirements
- R1: In buffered mode (fifoEn=1) with rxIntEn=1, dataAvailIrq is high in the same cycle in which fifoCount is greater than or equal to the selected level, and low in the same cycle in which fifoCount is below it.
- R2: trigSel selects the level: 0 selects 1 entry, 1 selects 4, 2 selects 8 and 3 selects 14.
- R3: The timeout length is (4*W+12)*16 pulses of baudTick, where W = 5 + wordLenSel (0 to 3 encodes 5 to 8 bits). timeoutIrq rises after the edge that carries the final pulse counted from the last timer restart.
- R4: While no timeout is pending, a pushStb or popStb restarts the timer. While fifoCount is 0, the timer is held at zero and no timeout occurs.
- R5: While a timeout is pending, a pushStb neither clears it nor restarts the timer. A popStb clears timeoutIrq at the next edge and restarts the timer from zero.
- R6: In buffered mode, dmaReady rises at the edge after fifoCount reaches the level or after a timeout fires. It then stays high until the edge after fifoCount is seen at 0.
- R7: In unbuffered mode (fifoEn=0), pushStb sets a full flag at the next edge, and popStb without pushStb clears it. Both dataAvailIrq (when enabled) and dmaReady follow the flag, and timeoutIrq stays low.
- R8: rxIntEn=0 forces dataAvailIrq and timeoutIrq low. It affects neither the timer nor dmaReady, so a timeout that is pending appears as soon as rxIntEn returns to 1.
- R9: During and after reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1 selects buffered mode, 0 selects the single holding register |
| rxIntEn | input | 1 | Enable for both receive interrupts |
| trigSel | input | 2 | Fill threshold select |
| wordLenSel | input | 2 | Data word length, 0 to 3 for 5 to 8 bits |
| baudTick | input | 1 | Enable strobe at 16 times the bit rate |
| pushStb | input | 1 | A character is written into the buffer this cycle |
| popStb | input | 1 | The host reads a character this cycle |
| fifoCount | input | CNT_W | Current buffer occupancy |
| dataAvailIrq | output | 1 | Data-available interrupt |
| timeoutIrq | output | 1 | Character-timeout interrupt |
| dmaReady | output | 1 | DMA service request |

## Verification
The assertions assume that fifoCount agrees with the strobes. A pop is never issued while the count is zero, and the count changes one cycle after the push or pop that causes it, as a real buffer would behave. The bench keeps its own occupancy value and changes fifoCount only together with, or right after, the strobe it models. It lowers baudTick in every cycle that carries a strobe, so each timer restart is an exact point from which pulses are counted. Mode and level inputs change only while the buffer is empty or between test sections, so no property sees a threshold move beneath a pending request.

// File: rtl/rxsvc_pkg.sv
package rxsvc_pkg;

  // Control-to-datapath timer strobes
  typedef struct packed {
    logic timerClr;
    logic timerRun;
  } ctl2dp_t;

  // Datapath status toward control
  typedef struct packed {
    logic atTrig;
    logic cntEmpty;
    logic timerDone;
  } dp2ctl_t;

endpackage

// File: rtl/rxsvc_datapath.sv
module rxsvc_datapath
  import rxsvc_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int OVS      = 16,
  parameter int MIN_WORD = 5,
  parameter int TO_MULT  = 4,
  parameter int TO_BASE  = 12,
  parameter int TRIG0    = 1,
  parameter int TRIG1    = 4,
  parameter int TRIG2    = 8,
  parameter int TRIG3    = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             baudTick,
  input  logic [1:0]       trigSel,
  input  logic [1:0]       wordLenSel,
  input  ctl2dp_t          ctl,
  output dp2ctl_t          dpSt
);

  localparam int MAX_TICKS = (TO_MULT * (MIN_WORD + 3) + TO_BASE) * OVS;
  localparam int TMR_W     = $clog2(MAX_TICKS);

  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] limitM1;
  logic [CNT_W-1:0] trigLvl;
  logic             lastTick;

  // Threshold decode
  always_comb begin
    unique case (trigSel)
      2'd0:    trigLvl = CNT_W'(TRIG0);
      2'd1:    trigLvl = CNT_W'(TRIG1);
      2'd2:    trigLvl = CNT_W'(TRIG2);
      default: trigLvl = CNT_W'(TRIG3);
    endcase
  end

  // Timeout length in oversample ticks, minus one
  always_comb begin
    limitM1 = TMR_W'((TO_MULT * (MIN_WORD + int'(wordLenSel)) + TO_BASE) * OVS - 1);
  end

  assign lastTick       = (timer == limitM1);
  assign dpSt.atTrig    = (fifoCount >= trigLvl);
  assign dpSt.cntEmpty  = (fifoCount == '0);
  assign dpSt.timerDone = ctl.timerRun && !ctl.timerClr && baudTick && lastTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (ctl.timerClr) begin
      timer <= '0;
    end else if (ctl.timerRun && baudTick) begin
      if (lastTick) timer <= '0;
      else          timer <= timer + 1'b1;
    end
  end

  // R4
  // empty_hold_chk: an empty buffer leaves the timer at zero
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpSt.cntEmpty |=> (timer == '0));

  // R3
  // timer_stall_chk: without run or tick the timer keeps its value or clears
  timer_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.timerClr && !(ctl.timerRun && baudTick)) |=> $stable(timer));

endmodule

// File: rtl/rxsvc_ctrl.sv
module rxsvc_ctrl
  import rxsvc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fifoEn,
  input  logic    rxIntEn,
  input  logic    pushStb,
  input  logic    popStb,
  input  dp2ctl_t dpSt,
  output ctl2dp_t ctl,
  output logic    dataAvailIrq,
  output logic    timeoutIrq,
  output logic    dmaReady
);

  logic toFlag;
  logic dmaFlag;
  logic holdFull;

  always_comb begin
    ctl.timerClr = !fifoEn || dpSt.cntEmpty || popStb || (pushStb && !toFlag);
    ctl.timerRun = fifoEn && !toFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toFlag   <= 1'b0;
      dmaFlag  <= 1'b0;
      holdFull <= 1'b0;
    end else begin
      if (fifoEn)       holdFull <= 1'b0;
      else if (pushStb) holdFull <= 1'b1;
      else if (popStb)  holdFull <= 1'b0;

      if (!fifoEn || popStb)   toFlag <= 1'b0;
      else if (dpSt.timerDone) toFlag <= 1'b1;

      if (!fifoEn || dpSt.cntEmpty)         dmaFlag <= 1'b0;
      else if (dpSt.atTrig || dpSt.timerDone) dmaFlag <= 1'b1;
    end
  end

  assign dataAvailIrq = rxIntEn && (fifoEn ? dpSt.atTrig : holdFull);
  assign timeoutIrq   = rxIntEn && toFlag;
  assign dmaReady     = fifoEn ? dmaFlag : holdFull;

  // R5
  // pop_clears_to_chk: a host read removes a pending timeout
  pop_clears_to_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && popStb) |=> !toFlag);

  // R6
  // dma_hold_chk: the request persists while characters remain
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && dmaFlag && !dpSt.cntEmpty) |=> dmaFlag);

  // R7
  // hold_set_chk: a write in unbuffered mode fills the holding flag
  hold_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && pushStb) |=> holdFull);

  // R7
  // hold_clr_chk: a lone read in unbuffered mode empties it
  hold_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && popStb && !pushStb) |=> !holdFull);

endmodule

// File: rtl/rx_svc_ctrl.sv
module rx_svc_ctrl
  import rxsvc_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int OVS      = 16,
  parameter int MIN_WORD = 5,
  parameter int TO_MULT  = 4,
  parameter int TO_BASE  = 12,
  parameter int TRIG0    = 1,
  parameter int TRIG1    = 4,
  parameter int TRIG2    = 8,
  parameter int TRIG3    = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             rxIntEn,
  input  logic [1:0]       trigSel,
  input  logic [1:0]       wordLenSel,
  input  logic             baudTick,
  input  logic             pushStb,
  input  logic             popStb,
  input  logic [CNT_W-1:0] fifoCount,
  output logic             dataAvailIrq,
  output logic             timeoutIrq,
  output logic             dmaReady
);

  ctl2dp_t ctl;
  dp2ctl_t dpSt;

  rxsvc_datapath #(
    .CNT_W(CNT_W), .OVS(OVS), .MIN_WORD(MIN_WORD), .TO_MULT(TO_MULT),
    .TO_BASE(TO_BASE), .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)
  ) dp_i (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .baudTick(baudTick),
    .trigSel(trigSel), .wordLenSel(wordLenSel), .ctl(ctl), .dpSt(dpSt)
  );

  rxsvc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxIntEn(rxIntEn),
    .pushStb(pushStb), .popStb(popStb), .dpSt(dpSt), .ctl(ctl),
    .dataAvailIrq(dataAvailIrq), .timeoutIrq(timeoutIrq), .dmaReady(dmaReady)
  );

endmodule

// File: tb/rx_svc_ctrl_tb.sv
`timescale 1ns/1ps
module rx_svc_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN, fifoEn, rxIntEn, baudTick, pushStb, popStb;
  logic [1:0] trigSel, wordLenSel;
  logic [4:0] fifoCount;
  logic       dataAvailIrq, timeoutIrq, dmaReady;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rx_svc_ctrl dut_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxIntEn(rxIntEn),
    .trigSel(trigSel), .wordLenSel(wordLenSel), .baudTick(baudTick),
    .pushStb(pushStb), .popStb(popStb), .fifoCount(fifoCount),
    .dataAvailIrq(dataAvailIrq), .timeoutIrq(timeoutIrq), .dmaReady(dmaReady)
  );

  // Vector fields: [9] fifoEn, [8] rxIntEn, [7:6] trigSel, [5:1] fifoCount, [0] expected dataAvailIrq
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'd0, 5'd0,  1'b0},
    {1'b1, 1'b1, 2'd0, 5'd1,  1'b1},
    {1'b1, 1'b1, 2'd1, 5'd3,  1'b0},
    {1'b1, 1'b1, 2'd1, 5'd4,  1'b1},
    {1'b1, 1'b1, 2'd2, 5'd7,  1'b0},
    {1'b1, 1'b1, 2'd2, 5'd8,  1'b1},
    {1'b1, 1'b1, 2'd3, 5'd13, 1'b0},
    {1'b1, 1'b1, 2'd3, 5'd14, 1'b1},
    {1'b1, 1'b1, 2'd3, 5'd16, 1'b1},
    {1'b1, 1'b0, 2'd0, 5'd5,  1'b0},
    {1'b1, 1'b1, 2'd2, 5'd9,  1'b1},
    {1'b1, 1'b1, 2'd1, 5'd2,  1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pushPulse(input logic [4:0] newCount);
    pushStb = 1'b1; baudTick = 1'b0; fifoCount = newCount;
    tick();
    pushStb = 1'b0;
  endtask

  task automatic popPulse(input logic [4:0] newCount);
    popStb = 1'b1; baudTick = 1'b0;
    tick();
    popStb = 1'b0; fifoCount = newCount;
  endtask

  task automatic runTicks(input int n);
    baudTick = 1'b1;
    repeat (n) tick();
    baudTick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; fifoEn = 0; rxIntEn = 0; baudTick = 0; pushStb = 0; popStb = 0;
    trigSel = 0; wordLenSel = 0; fifoCount = 0;
    repeat (3) tick();
    chk("R9 avail in reset", dataAvailIrq, 1'b0);
    chk("R9 timeout in reset", timeoutIrq, 1'b0);
    chk("R9 dma in reset", dmaReady, 1'b0);
    rstN = 1; fifoEn = 1; rxIntEn = 1;
    tick();
    chk("R9 dma after reset", dmaReady, 1'b0);

    // R1 R2 threshold table
    for (int i = 0; i < NV; i++) begin
      fifoEn = VEC[i][9]; rxIntEn = VEC[i][8]; trigSel = VEC[i][7:6]; fifoCount = VEC[i][5:1];
      #1;
      chk($sformatf("R1/R2 vector %0d", i), dataAvailIrq, VEC[i][0]);
      tick();
    end
    rxIntEn = 1; fifoCount = 0;
    repeat (2) tick();

    // R6 dma hold until empty
    trigSel = 2'd1; fifoCount = 5'd4;
    tick();
    chk("R6 dma at level", dmaReady, 1'b1);
    fifoCount = 5'd2;
    tick();
    chk("R6 dma held below level", dmaReady, 1'b1);
    chk("R1 avail cleared below level", dataAvailIrq, 1'b0);
    fifoCount = 5'd0;
    tick();
    chk("R6 dma released when empty", dmaReady, 1'b0);

    // R3 word length 8: 44*16 ticks
    trigSel = 2'd3; wordLenSel = 2'd3;
    pushPulse(5'd1);
    runTicks(703);
    chk("R3 no timeout one tick early", timeoutIrq, 1'b0);
    chk("R6 no dma before timeout", dmaReady, 1'b0);
    runTicks(1);
    chk("R3 timeout at 704 ticks", timeoutIrq, 1'b1);
    chk("R6 dma on timeout", dmaReady, 1'b1);
    // R5 push keeps it pending
    pushPulse(5'd2);
    runTicks(5);
    chk("R5 push leaves timeout", timeoutIrq, 1'b1);
    popPulse(5'd1);
    chk("R5 pop clears timeout", timeoutIrq, 1'b0);
    runTicks(703);
    chk("R5 restarted timer early", timeoutIrq, 1'b0);
    runTicks(1);
    chk("R5 restarted timer full", timeoutIrq, 1'b1);
    popPulse(5'd0);
    tick();
    chk("R6 dma released after drain", dmaReady, 1'b0);
    runTicks(2000);
    chk("R4 empty holds timer", timeoutIrq, 1'b0);

    // R4 push restarts timer, word length 5: 32*16 ticks
    wordLenSel = 2'd0;
    pushPulse(5'd1);
    runTicks(300);
    pushPulse(5'd2);
    runTicks(511);
    chk("R4 push restarted timer", timeoutIrq, 1'b0);
    runTicks(1);
    chk("R3 timeout at 512 ticks", timeoutIrq, 1'b1);
    popPulse(5'd1);

    // R8 enable gates interrupts only
    rxIntEn = 0;
    runTicks(512);
    chk("R8 timeout masked", timeoutIrq, 1'b0);
    chk("R8 dma unaffected", dmaReady, 1'b1);
    rxIntEn = 1; #1;
    chk("R8 pending timeout shows", timeoutIrq, 1'b1);
    popPulse(5'd0);
    tick();

    // R7 unbuffered mode
    fifoEn = 0;
    tick();
    pushPulse(5'd0);
    chk("R7 avail after write", dataAvailIrq, 1'b1);
    chk("R7 dma after write", dmaReady, 1'b1);
    runTicks(1000);
    chk("R7 no timeout", timeoutIrq, 1'b0);
    rxIntEn = 0; #1;
    chk("R8 avail masked", dataAvailIrq, 1'b0);
    rxIntEn = 1;
    popPulse(5'd0);
    chk("R7 avail cleared by read", dataAvailIrq, 1'b0);
    chk("R7 dma cleared by read", dmaReady, 1'b0);
    pushPulse(5'd0);
    chk("R7 avail raised again", dataAvailIrq, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule